// File: doc/BRIEF.md
# Reset Source Arbiter and Architectural State Initializer

This block sits beside a processor core and decides when the core must restart and which kind of restart it is. It watches two active-low reset pins from outside the chip and two internal triggers: a general exception raised while the core already has exceptions blocked, and a watchdog overflow. A low main pin gives a power-on reset. Every other source gives a manual reset. When several sources are active at once, a fixed priority picks the one to report.

While a reset condition lasts, the block holds the restart state in its own registers. This state is the exception-event code, the vector base and the status fields: mode, register bank, block, FPU disable and interrupt mask. When the condition ends, the block gives one single-cycle strobe that loads the restart address into the program counter. In the same cycle it gives a peripheral-reset strobe, and the reset kind is reported next to it. Both pins pass through a synchronizer and a two-sample confirmation before the block acts on them.

Top module: `reset_source_arbiter`

## Requirements
- R1: When the main pin `por_pin_n` is held low for at least two clocks, a power-on reset is taken whatever level `mrst_pin_n` has. `rst_kind` becomes 2'b01 and `rst_src` becomes 2'b00.
- R2: When `mrst_pin_n` is held low for at least two clocks while `por_pin_n` is high, a manual reset is taken. `rst_kind` becomes 2'b10 and `rst_src` becomes 2'b01.
- R3: A cycle with `exc_valid`=1, `core_sr_bl`=1 and `exc_user_break`=0 gives a manual reset with `rst_src`=2'b10. An exception with `core_sr_bl`=0, or one flagged as a user break, changes no output.
- R4: A cycle with `wdt_overflow`=1 and `wdt_reset_sel`=1 gives a manual reset with `rst_src`=2'b11. An overflow with `wdt_reset_sel`=0 changes no output.
- R5: Sources active in the same cycle are ranked from highest to lowest as main pin, then manual pin, then blocked exception, then watchdog. `rst_src` reports the winner.
- R6: `expevt` is loaded with 32'h0000_0000 on a power-on reset and with 32'h0000_0020 on a manual reset.
- R7: On any reset, `vbr` becomes 0, `sr_md`, `sr_rb` and `sr_bl` become 1, `sr_fd` becomes 0 and `sr_imask` becomes 4'hF.
- R8: After the reset condition ends, `pc_load` and `periph_rst` are high together for exactly one clock. During that clock `pc_value` is 32'hA000_0000.
- R9: A pin that is low for only one sampled clock is ignored: no strobe is given and `rst_kind` does not change.
- R10: While the block reset `rst` is high, all state outputs, `rst_kind`, `rst_src` and both strobes are 0.
- R11: No strobe is given while any reset condition is still active, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of this block |
| por_pin_n | input | 1 | Main reset pin, active low, asynchronous |
| mrst_pin_n | input | 1 | Manual reset pin, active low, asynchronous |
| exc_valid | input | 1 | A general exception is raised this cycle |
| exc_user_break | input | 1 | The raised exception is a user break |
| core_sr_bl | input | 1 | Current block bit of the core status register |
| wdt_overflow | input | 1 | Watchdog overflow event |
| wdt_reset_sel | input | 1 | Watchdog is configured to reset on overflow |
| expevt | output | 32 | Exception-event code register |
| vbr | output | 32 | Vector base register |
| sr_md | output | 1 | Status register: privileged mode |
| sr_rb | output | 1 | Status register: register bank select |
| sr_bl | output | 1 | Status register: exception block bit |
| sr_fd | output | 1 | Status register: FPU disable |
| sr_imask | output | 4 | Status register: interrupt mask level |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_value | output | 32 | Restart address, valid with `pc_load` |
| periph_rst | output | 1 | One-cycle peripheral-reset strobe |
| rst_kind | output | 2 | Kind of the last reset: 00 none, 01 power-on, 10 manual |
| rst_src | output | 2 | Source of the last reset: 00 main pin, 01 manual pin, 10 blocked exception, 11 watchdog |

## Verification
The hardest cases to reach from the ports are the ones where sources collide. One is an internal trigger that arrives while a reset pin is already held and confirmed. Another is a pin pulse short enough that the confirmation filter must drop it. The stimulus holds the manual pin low until it has passed the synchronizer. It then fires an exception and a watchdog overflow in the same cycle, and checks that the pin still wins. Separately, it drives a pin low between two falling edges, so that exactly one rising edge sees the low level. Random runs of internal events then vary the block bit, the user-break flag and the watchdog select. The results are checked against a bench model.

// File: rtl/reset_arb_pkg.sv
package reset_arb_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned NUM_PINS = 2;
    localparam int unsigned PIN_POR  = 0;
    localparam int unsigned PIN_MAN  = 1;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_POWER  = 2'b01,
        KIND_MANUAL = 2'b10
    } rst_kind_e;

    typedef enum logic [1:0] {
        SRC_POR_PIN = 2'b00,
        SRC_MAN_PIN = 2'b01,
        SRC_BLK_EXC = 2'b10,
        SRC_WDT     = 2'b11
    } rst_src_e;

    typedef struct packed {
        logic       md;
        logic       rb;
        logic       bl;
        logic       fd;
        logic [3:0] imask;
    } sr_fields_t;

    typedef struct packed {
        logic      any;
        rst_kind_e kind;
        rst_src_e  src;
    } rst_req_t;

    localparam logic [REG_W-1:0] EXPEVT_POWER  = 32'h0000_0000;
    localparam logic [REG_W-1:0] EXPEVT_MANUAL = 32'h0000_0020;
    localparam logic [REG_W-1:0] VBR_INIT      = 32'h0000_0000;
    localparam logic [REG_W-1:0] PC_RESTART    = 32'hA000_0000;

    function automatic sr_fields_t sr_restart_value();
        sr_fields_t s;
        s.md    = 1'b1;
        s.rb    = 1'b1;
        s.bl    = 1'b1;
        s.fd    = 1'b0;
        s.imask = 4'hF;
        return s;
    endfunction

    function automatic logic [REG_W-1:0] expevt_code(rst_kind_e k);
        return (k == KIND_POWER) ? EXPEVT_POWER : EXPEVT_MANUAL;
    endfunction

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CONFIRM     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic active
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [CONFIRM-1:0]     hist_q;
    logic                   level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            hist_q  <= '1;
            level_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            hist_q <= {hist_q[CONFIRM-2:0], sync_q[SYNC_STAGES-1]};
            // level changes only after CONFIRM equal synchronized samples
            if (&hist_q)
                level_q <= 1'b1;
            else if (~|hist_q)
                level_q <= 1'b0;
        end
    end

    assign active = ~level_q;
endmodule

// File: rtl/rst_source_select.sv
module rst_source_select
    import reset_arb_pkg::*;
(
    input  logic     por_act,
    input  logic     man_act,
    input  logic     exc_valid,
    input  logic     exc_user_break,
    input  logic     core_sr_bl,
    input  logic     wdt_overflow,
    input  logic     wdt_reset_sel,
    output rst_req_t req
);
    logic exc_hit;
    logic wdt_hit;

    assign exc_hit = exc_valid & core_sr_bl & ~exc_user_break;
    assign wdt_hit = wdt_overflow & wdt_reset_sel;

    always_comb begin
        req.any  = 1'b0;
        req.kind = KIND_NONE;
        req.src  = SRC_POR_PIN;
        if (por_act) begin
            req.any  = 1'b1;
            req.kind = KIND_POWER;
            req.src  = SRC_POR_PIN;
        end else if (man_act) begin
            req.any  = 1'b1;
            req.kind = KIND_MANUAL;
            req.src  = SRC_MAN_PIN;
        end else if (exc_hit) begin
            req.any  = 1'b1;
            req.kind = KIND_MANUAL;
            req.src  = SRC_BLK_EXC;
        end else if (wdt_hit) begin
            req.any  = 1'b1;
            req.kind = KIND_MANUAL;
            req.src  = SRC_WDT;
        end
    end
endmodule

// File: rtl/rst_state_init.sv
module rst_state_init
    import reset_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rst_req_t         req,
    output logic [REG_W-1:0] expevt,
    output logic [REG_W-1:0] vbr,
    output sr_fields_t       sr,
    output logic             restart,
    output rst_kind_e        kind,
    output rst_src_e         src
);
    logic in_reset_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            expevt     <= '0;
            vbr        <= '0;
            sr         <= '0;
            restart    <= 1'b0;
            kind       <= KIND_NONE;
            src        <= SRC_POR_PIN;
            in_reset_q <= 1'b0;
        end else begin
            restart <= 1'b0;
            if (req.any) begin
                in_reset_q <= 1'b1;
                kind       <= req.kind;
                src        <= req.src;
                expevt     <= expevt_code(req.kind);
                vbr        <= VBR_INIT;
                sr         <= sr_restart_value();
            end else if (in_reset_q) begin
                in_reset_q <= 1'b0;
                restart    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/reset_source_arbiter.sv
module reset_source_arbiter
    import reset_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        por_pin_n,
    input  logic        mrst_pin_n,
    input  logic        exc_valid,
    input  logic        exc_user_break,
    input  logic        core_sr_bl,
    input  logic        wdt_overflow,
    input  logic        wdt_reset_sel,
    output logic [31:0] expevt,
    output logic [31:0] vbr,
    output logic        sr_md,
    output logic        sr_rb,
    output logic        sr_bl,
    output logic        sr_fd,
    output logic [3:0]  sr_imask,
    output logic        pc_load,
    output logic [31:0] pc_value,
    output logic        periph_rst,
    output logic [1:0]  rst_kind,
    output logic [1:0]  rst_src
);
    logic [NUM_PINS-1:0] pin_n_vec;
    logic [NUM_PINS-1:0] pin_act;
    rst_req_t            req;
    sr_fields_t          sr_q;
    logic                restart;
    rst_kind_e           kind_q;
    rst_src_e            src_q;

    assign pin_n_vec[PIN_POR] = por_pin_n;
    assign pin_n_vec[PIN_MAN] = mrst_pin_n;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        rst_pin_filter #(.SYNC_STAGES(2), .CONFIRM(2)) u_filter (
            .clk    (clk),
            .rst    (rst),
            .pin_n  (pin_n_vec[g]),
            .active (pin_act[g])
        );
    end

    rst_source_select u_select (
        .por_act        (pin_act[PIN_POR]),
        .man_act        (pin_act[PIN_MAN]),
        .exc_valid      (exc_valid),
        .exc_user_break (exc_user_break),
        .core_sr_bl     (core_sr_bl),
        .wdt_overflow   (wdt_overflow),
        .wdt_reset_sel  (wdt_reset_sel),
        .req            (req)
    );

    rst_state_init u_state (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .expevt  (expevt),
        .vbr     (vbr),
        .sr      (sr_q),
        .restart (restart),
        .kind    (kind_q),
        .src     (src_q)
    );

    assign sr_md      = sr_q.md;
    assign sr_rb      = sr_q.rb;
    assign sr_bl      = sr_q.bl;
    assign sr_fd      = sr_q.fd;
    assign sr_imask   = sr_q.imask;
    assign pc_load    = restart;
    assign periph_rst = restart;
    assign pc_value   = restart ? PC_RESTART : '0;
    assign rst_kind   = kind_q;
    assign rst_src    = src_q;
endmodule

// File: rtl/reset_arb_checker.sv
module reset_arb_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] expevt,
    input logic [31:0] vbr,
    input logic        sr_md,
    input logic        sr_rb,
    input logic        sr_bl,
    input logic        sr_fd,
    input logic [3:0]  sr_imask,
    input logic        pc_load,
    input logic [1:0]  rst_kind,
    input logic [1:0]  rst_src
);
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);

    assert_strobe_has_kind_R8: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (rst_kind != 2'b00));

    assert_sr_on_restart_R7: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (sr_md && sr_rb && sr_bl && !sr_fd && sr_imask == 4'hF && vbr == 32'h0));

    assert_manual_code_R6: assert property (@(posedge clk) disable iff (rst)
        (pc_load && rst_kind == 2'b10) |-> expevt == 32'h0000_0020);

    assert_power_code_R6: assert property (@(posedge clk) disable iff (rst)
        (pc_load && rst_kind == 2'b01) |-> expevt == 32'h0000_0000);

    assert_kind_legal_R1: assert property (@(posedge clk) disable iff (rst)
        rst_kind != 2'b11);

    assert_power_from_pin_R5: assert property (@(posedge clk) disable iff (rst)
        (rst_kind == 2'b01) |-> rst_src == 2'b00);

    assert_internal_is_manual_R3: assert property (@(posedge clk) disable iff (rst)
        (rst_src != 2'b00) |-> rst_kind == 2'b10);
endmodule

bind reset_source_arbiter reset_arb_checker i_checker (.*);

// File: tb/test_reset_source_arbiter.sv
module test_reset_source_arbiter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_pin_n = 1'b1, mrst_pin_n = 1'b1;
    logic exc_valid = 1'b0, exc_user_break = 1'b0, core_sr_bl = 1'b0;
    logic wdt_overflow = 1'b0, wdt_reset_sel = 1'b0;
    logic [31:0] expevt, vbr, pc_value;
    logic sr_md, sr_rb, sr_bl, sr_fd, pc_load, periph_rst;
    logic [3:0] sr_imask;
    logic [1:0] rst_kind, rst_src;

    int tests = 0, fails = 0;
    int pulse_cnt = 0;
    int double_cnt = 0;
    logic [31:0] pc_seen = '0;
    logic prev_pulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_source_arbiter i_reset_source_arbiter (.*);

    always @(negedge clk) begin
        if (pc_load) begin
            pulse_cnt++;
            pc_seen = pc_value;
            if (prev_pulse) double_cnt++;
            if (!periph_rst) double_cnt++;
        end
        prev_pulse = pc_load;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_code(input logic [1:0] k);
        return (k == 2'b01) ? 32'h0 : 32'h20;
    endfunction

    task automatic check_state(input logic [1:0] k, input logic [1:0] s, input string tag);
        chk(rst_kind == k, {tag, " kind"}, rst_kind, k);
        chk(rst_src == s, {tag, " src"}, rst_src, s);
        chk(expevt == exp_code(k), {tag, " expevt R6"}, expevt, exp_code(k));
        chk({sr_md, sr_rb, sr_bl, sr_fd, sr_imask, vbr} == {4'b1110, 4'hF, 32'h0},
            {tag, " sr/vbr R7"}, {sr_md, sr_rb, sr_bl, sr_fd, sr_imask}, 8'hEF);
    endtask

    task automatic pulse_internal(input logic e, input logic ub, input logic bl,
                                  input logic w, input logic sel);
        exc_valid = e; exc_user_break = ub; core_sr_bl = bl;
        wdt_overflow = w; wdt_reset_sel = sel;
        @(negedge clk);
        exc_valid = 0; exc_user_break = 0; core_sr_bl = 0;
        wdt_overflow = 0; wdt_reset_sel = 0;
    endtask

    task automatic power_on(input int hold);
        pulse_cnt = 0;
        por_pin_n = 0; idle(hold); por_pin_n = 1; idle(10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle(3);
        // R10: block reset state
        chk({expevt, vbr, sr_md, sr_rb, sr_bl, sr_fd, sr_imask, rst_kind, rst_src, pc_load, periph_rst} == '0,
            "R10 reset state", rst_kind, 0);
        rst = 0; idle(4);
        chk(rst_kind == 2'b00 && pulse_cnt == 0, "R10 idle after reset", rst_kind, 0);

        // R1/R11: long power-on hold, no strobe while held
        pulse_cnt = 0;
        por_pin_n = 0; idle(20);
        chk(pulse_cnt == 0, "R11 no strobe while held", pulse_cnt, 0);
        check_state(2'b01, 2'b00, "R1 power-on");
        por_pin_n = 1; idle(10);
        chk(pulse_cnt == 1 && double_cnt == 0, "R8 single strobe", pulse_cnt, 1);
        chk(pc_seen == 32'hA000_0000, "R8 pc value", pc_seen, 32'hA000_0000);

        // R2: manual pin
        pulse_cnt = 0;
        mrst_pin_n = 0; idle(12);
        check_state(2'b10, 2'b01, "R2 manual pin");
        mrst_pin_n = 1; idle(10);
        chk(pulse_cnt == 1, "R2 manual strobe", pulse_cnt, 1);

        // R1/R5: both pins low, main pin wins
        pulse_cnt = 0;
        por_pin_n = 0; mrst_pin_n = 0; idle(12);
        check_state(2'b01, 2'b00, "R5 both pins");
        por_pin_n = 1; mrst_pin_n = 1; idle(12);
        chk(pulse_cnt == 1, "R5 both pins strobe", pulse_cnt, 1);

        // R9: single-clock glitch on manual pin ignored
        pulse_cnt = 0;
        mrst_pin_n = 0; @(negedge clk); mrst_pin_n = 1; idle(10);
        chk(pulse_cnt == 0, "R9 glitch no strobe", pulse_cnt, 0);
        chk(rst_kind == 2'b01, "R9 glitch kind kept", rst_kind, 1);

        // R3: non-blocked and user-break exceptions ignored
        pulse_internal(1, 0, 0, 0, 0); idle(4);
        pulse_internal(1, 1, 1, 0, 0); idle(4);
        chk(pulse_cnt == 0 && rst_kind == 2'b01, "R3 ignored exceptions", rst_kind, 1);
        pulse_internal(1, 0, 1, 0, 0); idle(4);
        check_state(2'b10, 2'b10, "R3 blocked exception");
        chk(pulse_cnt == 1, "R3 strobe", pulse_cnt, 1);

        // R4: watchdog
        power_on(6);
        pulse_cnt = 0;
        pulse_internal(0, 0, 0, 1, 0); idle(4);
        chk(pulse_cnt == 0 && rst_kind == 2'b01, "R4 overflow without select", rst_kind, 1);
        pulse_internal(0, 0, 0, 1, 1); idle(4);
        check_state(2'b10, 2'b11, "R4 watchdog reset");
        chk(pulse_cnt == 1, "R4 strobe", pulse_cnt, 1);

        // R5: exception beats watchdog in the same cycle
        pulse_cnt = 0;
        pulse_internal(1, 0, 1, 1, 1); idle(4);
        chk(rst_src == 2'b10 && pulse_cnt == 1, "R5 exc over wdt", rst_src, 2);

        // R5: held manual pin beats internal events
        pulse_cnt = 0;
        mrst_pin_n = 0; idle(8);
        pulse_internal(1, 0, 1, 1, 1); idle(2);
        chk(rst_src == 2'b01, "R5 pin over internal", rst_src, 1);
        chk(pulse_cnt == 0, "R11 no strobe mid hold", pulse_cnt, 0);
        mrst_pin_n = 1; idle(10);
        chk(pulse_cnt == 1, "R5 pin hold strobe", pulse_cnt, 1);

        // Random internal events against a model
        power_on(6);
        begin
            logic [1:0] mk, ms;
            mk = 2'b01; ms = 2'b00;
            for (int i = 0; i < 60; i++) begin
                logic e, ub, bl, w, sel, eh, wh;
                e = 1'($urandom); ub = 1'($urandom); bl = 1'($urandom);
                w = 1'($urandom); sel = 1'($urandom);
                eh = e & bl & ~ub;
                wh = w & sel;
                pulse_cnt = 0;
                pulse_internal(e, ub, bl, w, sel); idle(4);
                if (eh || wh) begin
                    mk = 2'b10; ms = eh ? 2'b10 : 2'b11;
                end
                chk(pulse_cnt == ((eh || wh) ? 1 : 0), "R3 R4 random strobe", pulse_cnt, (eh || wh) ? 1 : 0);
                chk(rst_kind == mk && rst_src == ms, "R5 random kind/src", {rst_kind, rst_src}, {mk, ms});
                chk(expevt == exp_code(mk), "R6 random expevt", expevt, exp_code(mk));
            end
        end
        chk(double_cnt == 0, "R8 no wide strobe", double_cnt, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule